// File: doc/BRIEF.md
# ADC Conversion Trigger Conditioner

This block owns the conversion-start bit that an ADC sequencer watches. The bit can be set in three ways: a software write, a qualified edge or level on an external trigger pin, or a one-cycle pulse from a PWM unit. Software can also clear it, and the sequencer clears it when a conversion run ends. The external pin is asynchronous. It passes through a flop synchronizer and then a qualifier. The qualifier accepts a level only after that level has held for a minimum number of clocks. It accepts an edge only when the pin has held long enough on both sides of the transition.

A 2-bit source select chooses between the pin and the PWM pulse. An enable bit gates the pin path. A 2-bit condition field picks low level, high level, falling edge or rising edge. A qualified level raises one request per visit to the active level, so a pin held at the active level does not retrigger after the sequencer clears the bit. A software write in a given cycle overrides any hardware event in that cycle.

Top module: `adc_trig_cond`

## Requirements
- R1: After a synchronous active-low reset, `start_bit` reads 0.
- R2: With `src_sel`=0 and `trig_en`=1, a qualified pin event raises `start_bit` after a fixed latency. If the pin changes just after clock edge N, the bit first reads 1 after edge N+SYNC_STAGES+LEVEL_HOLD+1 for a level condition and after edge N+SYNC_STAGES+EDGE_HOLD+1 for an edge condition.
- R3: `trig_cond` encodes 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. Bit 0 gives the active pin value and bit 1 selects edge qualification.
- R4: A pin level held for fewer than LEVEL_HOLD (default 8) synchronized clocks raises no request.
- R5: An edge raises a request only if the pin held its old value for at least EDGE_HOLD (default 4) clocks before the transition and holds its new value for EDGE_HOLD clocks after it.
- R6: One stay at the active level produces exactly one request. The qualifier re-arms only after the synchronized pin leaves the active level.
- R7: While `trig_en` is 0, pin events raise no request. An event that qualifies while disabled is discarded and does not fire later when the enable is set.
- R8: `src_sel` encodes 0 = external pin and 3 = PWM pulse. With `src_sel`=3, a `pwm_trig` high in the cycle before edge N sets `start_bit` at edge N. Values 1 and 2 select no source, so neither the pin nor `pwm_trig` can set the bit.
- R9: A cycle with `sw_wr`=1 loads `sw_val` into `start_bit` at the next edge, whatever hardware trigger or `conv_done` occurs in the same cycle.
- R10: `conv_done` clears `start_bit` at the next edge unless a hardware trigger fires in the same cycle, in which case the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Software write strobe for the start bit |
| sw_val | input | 1 | Value written by software |
| trig_en | input | 1 | Enables the external pin trigger |
| src_sel | input | 2 | Hardware source: 0 pin, 3 PWM, 1/2 none |
| trig_cond | input | 2 | Pin condition: 0 low, 1 high, 2 fall, 3 rise |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| pwm_trig | input | 1 | Synchronous one-cycle PWM trigger pulse |
| conv_done | input | 1 | Sequencer end-of-run strobe, clears the bit |
| start_bit | output | 1 | Conversion-start request to the sequencer |

## Verification
The pin is tried with long holds, short glitches and pulses that fall just under the hold time on either side of a transition, in all four conditions. This separates correct level and edge qualification from an off-by-one in the hold counter or a missing check on the pre-transition side. A level held far beyond the hold time, then cleared by `conv_done`, shows whether re-arming is tied to leaving the level. Same-cycle collisions of a software write, a PWM pulse and `conv_done` show the priority order. Enabling the pin path while the pin already holds a qualified level, and pulsing under reserved source codes, show that the enable and the select discard events instead of deferring them.

// File: rtl/adc_trig_pkg.sv
// Package: shared encodings for the ADC trigger conditioner.
// Assumes the condition and source codes stay 2 bits wide.
package adc_trig_pkg;

    typedef enum logic [1:0] {
        COND_LOW  = 2'd0,
        COND_HIGH = 2'd1,
        COND_FALL = 2'd2,
        COND_RISE = 2'd3
    } trig_cond_e;

    typedef enum logic [1:0] {
        SRC_PIN  = 2'd0,
        SRC_RSV1 = 2'd1,
        SRC_RSV2 = 2'd2,
        SRC_PWM  = 2'd3
    } trig_src_e;

    // Edge conditions carry bit 1 set.
    function automatic logic cond_is_edge(trig_cond_e c);
        return c[1];
    endfunction

    // The pin value that counts as active (level) or as the new side (edge).
    function automatic logic cond_active_value(trig_cond_e c);
        return c[0];
    endfunction

endpackage

// File: rtl/atc_sync.sv
// Module: atc_sync
// Brings an asynchronous single-bit input into the clk domain through a
// chain of STAGES flops. Assumes the input is a slow control signal; no
// pulse narrower than a clock period is expected to survive.
module atc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    generate
        if (STAGES == 1) begin : g_single
            logic stage_q;
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= async_in;
            end
            assign sync_out = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the pin through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
            assign sync_out = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/atc_qual.sv
// Module: atc_qual
// Qualifies the synchronized trigger pin as a level or an edge. One run
// counter tracks how long the pin has held its current value. A flag
// remembers whether the previous value lasted EDGE_HOLD clocks. An arm
// flag limits each stay at the active level to one event. Events that
// qualify while en is low are consumed and dropped.
// Assumes LEVEL_HOLD >= 1 and EDGE_HOLD >= 1.
module atc_qual
    import adc_trig_pkg::*;
#(
    parameter int LEVEL_HOLD = 8,
    parameter int EDGE_HOLD  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  trig_cond_e cond,
    input  logic       sync_in,
    output logic       fire_q
);

    localparam int SAT   = (LEVEL_HOLD > EDGE_HOLD) ? LEVEL_HOLD : EDGE_HOLD;
    localparam int CNT_W = $clog2(SAT + 1);

    logic             s_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_now;
    logic [CNT_W-1:0] need;
    logic             prev_ok_q;
    logic             prev_ok_now;
    logic             armed_q;
    logic             active;
    logic             is_edge;
    logic             cand;

    // Length of the current run, counting this cycle, saturating at SAT.
    always_comb begin
        if (sync_in != s_q)               run_now = CNT_W'(1);
        else if (run_q >= CNT_W'(SAT))    run_now = CNT_W'(SAT);
        else                              run_now = run_q + CNT_W'(1);
    end

    // Whether the value before the latest transition lasted EDGE_HOLD clocks.
    always_comb begin
        if (sync_in != s_q) prev_ok_now = (run_q >= CNT_W'(EDGE_HOLD));
        else                prev_ok_now = prev_ok_q;
    end

    // Decide whether the current condition qualifies this cycle.
    always_comb begin
        is_edge = cond_is_edge(cond);
        active  = (sync_in == cond_active_value(cond));
        need    = is_edge ? CNT_W'(EDGE_HOLD) : CNT_W'(LEVEL_HOLD);
        cand    = armed_q && active && (run_now >= need) &&
                  (!is_edge || prev_ok_now);
    end

    // Track pin history, the arm flag and the registered event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= 1'b0;
            run_q     <= '0;
            prev_ok_q <= 1'b0;
            armed_q   <= 1'b1;
            fire_q    <= 1'b0;
        end else begin
            s_q       <= sync_in;
            run_q     <= run_now;
            prev_ok_q <= prev_ok_now;
            fire_q    <= cand && en;
            if (cand)         armed_q <= 1'b0;
            else if (!active) armed_q <= 1'b1;
        end
    end

    // R6: one stay at the active level yields one event, never two in a row.
    p_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);

    // R7: no event leaves the qualifier in the cycle after it was disabled.
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fire_q);

    // R3: an event is only raised while the pin sat at the active value.
    p_active_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> ($past(sync_in) == $past(cond[0])));

endmodule

// File: rtl/atc_start_ctl.sv
// Module: atc_start_ctl
// Holds the conversion-start bit. Software writes win over everything.
// A hardware trigger wins over the sequencer's done strobe, so a trigger
// that lands at the end of a run is not lost.
module atc_start_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic hw_fire,
    input  logic seq_done,
    output logic start_q
);

    // Priority update of the start bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= 1'b0;
        else if (sw_wr)    start_q <= sw_val;
        else if (hw_fire)  start_q <= 1'b1;
        else if (seq_done) start_q <= 1'b0;
    end

    // R9: a software write decides the next value of the bit.
    p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (start_q == $past(sw_val)));

    // R10: a hardware trigger without a software write leaves the bit set.
    p_hw_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && hw_fire) |=> start_q);

    // R10: done alone clears the bit.
    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && !hw_fire && seq_done) |=> !start_q);

endmodule

// File: rtl/adc_trig_cond.sv
// Module: adc_trig_cond (top)
// Conditions the three conversion-start sources into one start bit.
// Path: pin -> synchronizer -> level/edge qualifier -> source select ->
// start-bit arbiter. The PWM pulse is assumed synchronous to clk and one
// cycle wide, so it enters the source select directly.
module adc_trig_cond
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LEVEL_HOLD  = 8,
    parameter int EDGE_HOLD   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic       sw_val,
    input  logic       trig_en,
    input  logic [1:0] src_sel,
    input  logic [1:0] trig_cond,
    input  logic       ext_pin,
    input  logic       pwm_trig,
    input  logic       conv_done,
    output logic       start_bit
);

    trig_cond_e cond_e;
    trig_src_e  src_e;
    logic       pin_sync;
    logic       pin_path_en;
    logic       pin_fire;
    logic       hw_fire;

    // Decode the raw control fields into the shared enums.
    always_comb begin
        cond_e      = trig_cond_e'(trig_cond);
        src_e       = trig_src_e'(src_sel);
        pin_path_en = trig_en && (src_e == SRC_PIN);
    end

    atc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_pin),
        .sync_out (pin_sync)
    );

    atc_qual #(
        .LEVEL_HOLD (LEVEL_HOLD),
        .EDGE_HOLD  (EDGE_HOLD)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pin_path_en),
        .cond    (cond_e),
        .sync_in (pin_sync),
        .fire_q  (pin_fire)
    );

    // Select the hardware source; reserved codes select nothing.
    always_comb begin
        case (src_e)
            SRC_PIN: hw_fire = pin_fire && pin_path_en;
            SRC_PWM: hw_fire = pwm_trig;
            default: hw_fire = 1'b0;
        endcase
    end

    atc_start_ctl u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (sw_wr),
        .sw_val   (sw_val),
        .hw_fire  (hw_fire),
        .seq_done (conv_done),
        .start_q  (start_bit)
    );

    // R8: under a reserved source code only software can raise the bit.
    p_reserved_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_sel == 2'd1 || src_sel == 2'd2) && !sw_wr) |=> !$rose(start_bit));

    // R1: the bit is clear in the first cycle after reset.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !start_bit);

endmodule

// File: tb/adc_trig_cond_bench.sv
// Scoreboard bench: the driver pushes the expected cycle of each start-bit
// rise into a queue, and the monitor pops and compares on every rise.
module adc_trig_cond_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SYN = 2;
    localparam int LVL = 8;
    localparam int EDG = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_wr = 1'b0;
    logic       sw_val = 1'b0;
    logic       trig_en = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] trig_cond = 2'd1;
    logic       ext_pin = 1'b0;
    logic       pwm_trig = 1'b0;
    logic       conv_done = 1'b0;
    logic       start_bit;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    exp_q[$];
    string tag_q[$];
    string cur_tag = "R1";
    logic  prev_start = 1'b0;

    adc_trig_cond u_adc_trig_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (sw_wr),
        .sw_val    (sw_val),
        .trig_en   (trig_en),
        .src_sel   (src_sel),
        .trig_cond (trig_cond),
        .ext_pin   (ext_pin),
        .pwm_trig  (pwm_trig),
        .conv_done (conv_done),
        .start_bit (start_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every rise of the start bit must match the queue head.
    always @(negedge clk) begin
        if (rst_n && start_bit && !prev_start) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: start rise at cycle %0d actual=1 expected=0",
                         cur_tag, cyc);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e != cyc) begin
                    errors++;
                    $display("FAIL %s: rise cycle actual=%0d expected=%0d", t, cyc, e);
                end
            end
        end
        prev_start = start_bit;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rise(input int at, input string tag);
        exp_q.push_back(at);
        tag_q.push_back(tag);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: start_bit actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic done_pulse();
        conv_done = 1'b1;
        step(1);
        conv_done = 1'b0;
    endtask

    // Wait, require every expected rise to have happened, then clear the bit.
    task automatic settle(input string tag);
        step(20);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: pending rises actual=%0d expected=0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
        done_pulse();
        step(2);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(start_bit, 1'b0, "R1");

        // R2 R3: high level qualified after LVL clocks.
        cur_tag = "R2";
        src_sel = 2'd0; trig_cond = 2'd1; trig_en = 1'b1;
        step(5);
        ext_pin = 1'b1;
        expect_rise(cyc + SYN + LVL + 1, "R2");
        step(30);
        // R6: held level does not retrigger after the sequencer clears.
        cur_tag = "R6";
        done_pulse();
        step(20);
        chk(start_bit, 1'b0, "R6");
        ext_pin = 1'b0;
        step(10);
        ext_pin = 1'b1;
        expect_rise(cyc + SYN + LVL + 1, "R6");
        step(20);
        ext_pin = 1'b0;
        settle("R6");

        // R4: a level shorter than LVL clocks is ignored.
        cur_tag = "R4";
        ext_pin = 1'b1;
        step(LVL - 3);
        ext_pin = 1'b0;
        step(20);
        chk(start_bit, 1'b0, "R4");
        settle("R4");

        // R3: low level condition.
        cur_tag = "R3";
        trig_en = 1'b0;
        ext_pin = 1'b1;
        step(10);
        trig_cond = 2'd0;
        step(5);
        trig_en = 1'b1;
        step(5);
        ext_pin = 1'b0;
        expect_rise(cyc + SYN + LVL + 1, "R3");
        step(20);
        ext_pin = 1'b1;
        settle("R3");

        // R3 R5: rising edge with enough low time before it.
        trig_en = 1'b0;
        ext_pin = 1'b0;
        trig_cond = 2'd3;
        step(10);
        trig_en = 1'b1;
        ext_pin = 1'b1;
        expect_rise(cyc + SYN + EDG + 1, "R3");
        step(20);
        done_pulse();
        // R5: low run of 3 before the rise disqualifies it.
        cur_tag = "R5";
        ext_pin = 1'b0;
        step(EDG - 1);
        ext_pin = 1'b1;
        step(20);
        chk(start_bit, 1'b0, "R5");
        // R5: high run of 3 after the rise disqualifies it.
        ext_pin = 1'b0;
        step(10);
        ext_pin = 1'b1;
        step(EDG - 1);
        ext_pin = 1'b0;
        step(20);
        chk(start_bit, 1'b0, "R5");
        settle("R5");

        // R3 R5: falling edge.
        cur_tag = "R3";
        trig_en = 1'b0;
        trig_cond = 2'd2;
        step(5);
        trig_en = 1'b1;
        ext_pin = 1'b1;
        step(10);
        ext_pin = 1'b0;
        expect_rise(cyc + SYN + EDG + 1, "R3");
        step(20);
        done_pulse();
        cur_tag = "R5";
        ext_pin = 1'b1;
        step(EDG - 1);
        ext_pin = 1'b0;
        step(20);
        chk(start_bit, 1'b0, "R5");
        settle("R5");

        // R7: disabled pin path discards a qualified level.
        cur_tag = "R7";
        trig_en = 1'b0;
        trig_cond = 2'd1;
        step(5);
        ext_pin = 1'b1;
        step(20);
        chk(start_bit, 1'b0, "R7");
        trig_en = 1'b1;
        step(20);
        chk(start_bit, 1'b0, "R7");
        ext_pin = 1'b0;
        settle("R7");

        // R8: reserved source codes select nothing.
        cur_tag = "R8";
        trig_en = 1'b0;
        src_sel = 2'd1;
        step(5);
        trig_en = 1'b1;
        ext_pin = 1'b1;
        step(20);
        pwm_trig = 1'b1;
        step(1);
        pwm_trig = 1'b0;
        step(3);
        chk(start_bit, 1'b0, "R8");
        src_sel = 2'd2;
        pwm_trig = 1'b1;
        step(1);
        pwm_trig = 1'b0;
        step(3);
        chk(start_bit, 1'b0, "R8");
        trig_en = 1'b0;
        ext_pin = 1'b0;
        settle("R8");

        // R8: PWM source sets the bit one edge after the pulse.
        src_sel = 2'd3;
        step(2);
        pwm_trig = 1'b1;
        expect_rise(cyc + 1, "R8");
        step(1);
        pwm_trig = 1'b0;
        step(2);
        chk(start_bit, 1'b1, "R8");
        settle("R8");

        // R9: software set, clear, and priority over PWM.
        cur_tag = "R9";
        sw_wr = 1'b1; sw_val = 1'b1;
        expect_rise(cyc + 1, "R9");
        step(1);
        sw_wr = 1'b0;
        chk(start_bit, 1'b1, "R9");
        sw_wr = 1'b1; sw_val = 1'b0; pwm_trig = 1'b1;
        step(1);
        sw_wr = 1'b0; pwm_trig = 1'b0;
        chk(start_bit, 1'b0, "R9");
        step(2);
        sw_wr = 1'b1; sw_val = 1'b0; pwm_trig = 1'b1;
        step(1);
        sw_wr = 1'b0; pwm_trig = 1'b0;
        chk(start_bit, 1'b0, "R9");
        settle("R9");

        // R10: PWM beats done; done alone clears.
        cur_tag = "R10";
        sw_wr = 1'b1; sw_val = 1'b1;
        expect_rise(cyc + 1, "R10");
        step(1);
        sw_wr = 1'b0;
        conv_done = 1'b1; pwm_trig = 1'b1;
        step(1);
        conv_done = 1'b0; pwm_trig = 1'b0;
        chk(start_bit, 1'b1, "R10");
        done_pulse();
        chk(start_bit, 1'b0, "R10");
        settle("R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule